// File: doc/BRIEF.md
# Iterative Newton-Raphson Reciprocal Unit

This block computes an approximation of 1/b for a signed fixed-point divisor. A one-cycle `start` pulse latches the divisor and loads a fixed seed of 0.5 into the estimate register. After that the unit applies the recurrence x' = x·(2 − x·b) once on every clock edge. It uses only two multiplies and one subtract, and each product is truncated and saturated back to the 9-bit format. Every intermediate estimate is visible on `estimate`. `iter_cnt` gives the number of updates applied since the last start.

The unit raises `converged` when two successive estimates differ by no more than the tolerance, or when the iteration limit is reached. The limit keeps the unit from running forever on inputs whose reciprocal is out of range, zero or negative. Once `converged` is set, the estimate and count stay frozen until the next `start`. A `start` pulse in any state restarts the computation.

The controller has three states:
- `ST_IDLE`: the state after reset.
- `ST_ITER`: one update per clock.
- `ST_DONE`: the result is held.

Its transitions are:
- `start` moves the unit from any state to `ST_ITER`.
- `ST_ITER` moves to `ST_DONE` on `near` (the step is within tolerance) or `last` (this update reaches the iteration limit).
- Otherwise `ST_ITER` stays in `ST_ITER`.
- `ST_IDLE` and `ST_DONE` stay where they are while `start` is low.

Top module: `nr_recip_unit`

## Requirements
- R1: Values use 9-bit two's complement with 7 fraction bits (0x080 = 1.0, 0x040 = 0.5, 0x180 = −1.0). One update computes p = sat(trunc(x·b / 128)), then d = 256 − p at 11-bit width (2.0 is not clipped), then x' = sat(trunc(x·d / 128)). Here trunc rounds toward minus infinity and sat clamps to the range [−256, 255].
- R2: On the clock edge where `start` is high, the unit latches `divisor`, loads `estimate` = 0x040, clears `iter_cnt` to 0 and clears `converged`. Later changes on `divisor` do not affect the running computation.
- R3: While iterating, each clock edge replaces `estimate` with the next value and increments `iter_cnt` by one. Every intermediate value appears on `estimate`.
- R4: `converged` rises on the same edge as the update for which |x' − x| ≤ 1 LSB, and not earlier. For b = 0x080 this yields `estimate` = 0x07F after 4 updates.
- R5: While `converged` is high and `start` is low, `estimate`, `iter_cnt` and `converged` stay unchanged whatever `divisor` does.
- R6: The update that brings `iter_cnt` to MAX_ITER (default 15) also sets `converged`, even when the tolerance has not been met.
- R7: A `start` pulse during a running computation restarts it with the new divisor. The estimate is reloaded to 0x040 and the count cleared.
- R8: After reset, `estimate` = 0x000, `iter_cnt` = 0 and `converged` = 0.
- R9: Saturation keeps out-of-range results at the rails. For b = 0x000, 0x180 and 0x100, the unit settles at 0x0FF after 3 updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Latch divisor and begin iterating |
| divisor | input | 9 | Signed divisor b, 7 fraction bits |
| estimate | output | 9 | Current estimate of 1/b |
| iter_cnt | output | 4 | Updates applied since start (width is clog2(MAX_ITER+1)) |
| converged | output | 1 | Tolerance met or limit reached |

## Verification
The bench builds two copies of the unit. The main copy uses the default limit of 15, and with it the bench covers converging divisors, zero, negative and out-of-range divisors, restart, and hold after completion. A second copy sets MAX_ITER to 2. With that setting the forced stop at the limit is reached by a divisor of 1.0, which would otherwise need four updates to converge. This makes it possible to check that the limit flag works independently of the tolerance test.

// File: rtl/nr_recip_pkg.sv
package nr_recip_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ITER = 2'd1,
        ST_DONE = 2'd2
    } nr_state_t;
endpackage

// File: rtl/nr_mul_sat.sv
// Signed multiply, arithmetic shift by FRAC, clamp into OW bits.
module nr_mul_sat #(
    parameter int AW   = 9,
    parameter int BW   = 9,
    parameter int OW   = 9,
    parameter int FRAC = 7
) (
    input  logic signed [AW-1:0] op_a,
    input  logic signed [BW-1:0] op_b,
    output logic signed [OW-1:0] res
);
    localparam int PW = AW + BW;
    localparam logic signed [PW-1:0] MAXV = {{(PW-OW+1){1'b0}}, {(OW-1){1'b1}}};
    localparam logic signed [PW-1:0] MINV = {{(PW-OW+1){1'b1}}, {(OW-1){1'b0}}};

    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] shifted;

    always_comb begin
        prod    = PW'(op_a) * PW'(op_b);
        shifted = prod >>> FRAC;
        if (shifted > MAXV)
            res = MAXV[OW-1:0];
        else if (shifted < MINV)
            res = MINV[OW-1:0];
        else
            res = shifted[OW-1:0];
    end
endmodule

// File: rtl/nr_step.sv
// One Newton-Raphson update: x' = x * (2 - x*b).
module nr_step #(
    parameter int W    = 9,
    parameter int FRAC = 7
) (
    input  logic signed [W-1:0] x_cur,
    input  logic signed [W-1:0] b_val,
    output logic signed [W-1:0] x_next
);
    localparam int DW = W + 2;
    localparam logic signed [DW-1:0] TWO = DW'(1) <<< (FRAC + 1);

    logic signed [W-1:0]  xb;
    logic signed [DW-1:0] corr;

    nr_mul_sat #(.AW(W), .BW(W), .OW(W), .FRAC(FRAC)) u_mul_xb (
        .op_a (x_cur),
        .op_b (b_val),
        .res  (xb)
    );

    always_comb corr = TWO - {{2{xb[W-1]}}, xb};

    nr_mul_sat #(.AW(W), .BW(DW), .OW(W), .FRAC(FRAC)) u_mul_xd (
        .op_a (x_cur),
        .op_b (corr),
        .res  (x_next)
    );

    always_comb begin
        a_r1_corr_positive: assert (corr > 0)
            else $error("R1: correction term not positive");
    end
endmodule

// File: rtl/nr_conv.sv
// Tolerance test between two successive estimates.
module nr_conv #(
    parameter int W   = 9,
    parameter int TOL = 1
) (
    input  logic signed [W-1:0] x_old,
    input  logic signed [W-1:0] x_new,
    output logic                near
);
    logic signed [W:0] delta;
    logic        [W:0] mag;

    always_comb begin
        delta = {x_new[W-1], x_new} - {x_old[W-1], x_old};
        mag   = delta[W] ? (W+1)'(-delta) : delta;
        near  = (mag <= (W+1)'(TOL));
    end
endmodule

// File: rtl/nr_ctrl.sv
// Sequencer: holds divisor, estimate, count and done flag.
module nr_ctrl
    import nr_recip_pkg::*;
#(
    parameter int              W        = 9,
    parameter int              MAX_ITER = 15,
    parameter int              CW       = 4,
    parameter logic [W-1:0]    SEED     = 9'h040
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [W-1:0]  b_in,
    input  logic [W-1:0]  x_next,
    input  logic          near,
    output logic [W-1:0]  b_q,
    output logic [W-1:0]  x_q,
    output logic [CW-1:0] cnt_q,
    output logic          done_q
);
    nr_state_t state, state_nx;
    logic      last;

    always_comb last = (cnt_q == CW'(MAX_ITER - 1));

    always_ff @(posedge clk) begin
        if (rst)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start) state_nx = ST_ITER;
            ST_ITER: begin
                if (start)
                    state_nx = ST_ITER;
                else if (near || last)
                    state_nx = ST_DONE;
            end
            ST_DONE: if (start) state_nx = ST_ITER;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            b_q    <= '0;
            x_q    <= '0;
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (start) begin
            b_q    <= b_in;
            x_q    <= SEED;
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (state == ST_ITER) begin
            x_q   <= x_next;
            cnt_q <= cnt_q + CW'(1);
            if (near || last)
                done_q <= 1'b1;
        end
    end

    a_r2_load: assert property (@(posedge clk) disable iff (rst)
        start |=> (x_q == SEED) && (cnt_q == '0) && !done_q)
        else $error("R2: start did not load seed");

    a_r3_count_step: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ITER) && !start |=> cnt_q == $past(cnt_q) + CW'(1))
        else $error("R3: count did not advance");

    a_r4_done_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(done_q) |-> ($past(state) == ST_ITER) && ($past(near) || $past(last)))
        else $error("R4: completion without cause");

    a_r4_no_early: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ITER) && !start && !near && !last |=> !done_q)
        else $error("R4: early completion");

    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        done_q && !start |=> done_q && $stable(x_q) && $stable(cnt_q))
        else $error("R5: result not held");

    a_r6_limit: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(MAX_ITER))
        else $error("R6: count beyond limit");
endmodule

// File: rtl/nr_recip_unit.sv
module nr_recip_unit #(
    parameter int W        = 9,
    parameter int FRAC     = 7,
    parameter int MAX_ITER = 15,
    parameter int TOL      = 1,
    parameter int CW       = $clog2(MAX_ITER + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [W-1:0]  divisor,
    output logic [W-1:0]  estimate,
    output logic [CW-1:0] iter_cnt,
    output logic          converged
);
    localparam logic [W-1:0] SEED = W'(1) << (FRAC - 1);

    logic [W-1:0] b_q, x_q, x_nx;
    logic         near;

    nr_step #(.W(W), .FRAC(FRAC)) u_step (
        .x_cur  (x_q),
        .b_val  (b_q),
        .x_next (x_nx)
    );

    nr_conv #(.W(W), .TOL(TOL)) u_conv (
        .x_old (x_q),
        .x_new (x_nx),
        .near  (near)
    );

    nr_ctrl #(.W(W), .MAX_ITER(MAX_ITER), .CW(CW), .SEED(SEED)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .b_in   (divisor),
        .x_next (x_nx),
        .near   (near),
        .b_q    (b_q),
        .x_q    (x_q),
        .cnt_q  (iter_cnt),
        .done_q (converged)
    );

    assign estimate = x_q;
endmodule

// File: tb/tb_nr_recip_unit.sv
`timescale 1ns/1ps
module tb_nr_recip_unit;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [8:0] divisor = '0;
    logic [8:0] estimate;
    logic [3:0] iter_cnt;
    logic       converged;

    logic       start_l = 1'b0;
    logic [8:0] estimate_l;
    logic [1:0] iter_cnt_l;
    logic       converged_l;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    nr_recip_unit dut (
        .clk(clk), .rst(rst), .start(start), .divisor(divisor),
        .estimate(estimate), .iter_cnt(iter_cnt), .converged(converged)
    );

    nr_recip_unit #(.MAX_ITER(2)) dut_lim (
        .clk(clk), .rst(rst), .start(start_l), .divisor(divisor),
        .estimate(estimate_l), .iter_cnt(iter_cnt_l), .converged(converged_l)
    );

    function automatic int clamp9(int v);
        if (v > 255) return 255;
        if (v < -256) return -256;
        return v;
    endfunction

    function automatic int sx9(logic [8:0] v);
        return int'($signed(v));
    endfunction

    function automatic int model_next(int x, int b);
        int p;
        p = clamp9((x * b) >>> 7);
        return clamp9((x * (256 - p)) >>> 7);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic t_reset();
        chk(estimate == 9'h000, "R8 estimate", int'(estimate), 0);
        chk(iter_cnt == 4'd0, "R8 count", int'(iter_cnt), 0);
        chk(converged == 1'b0, "R8 converged", int'(converged), 0);
    endtask

    // Runs one divisor; exp_x / exp_n < 0 means model only.
    task automatic t_case(input logic [8:0] bv, input int exp_x, input int exp_n);
        int mx, nx, b;
        bit done_e;
        b = sx9(bv);
        @(negedge clk); divisor = bv; start = 1'b1;
        @(negedge clk); start = 1'b0; divisor = ~bv;
        chk(estimate == 9'h040, "R2 seed", int'(estimate), 64);
        chk(iter_cnt == 0 && !converged, "R2 cleared", int'(iter_cnt), 0);
        mx = 64;
        for (int k = 1; k <= 15; k++) begin
            @(negedge clk);
            nx = model_next(mx, b);
            done_e = ((nx - mx) <= 1 && (mx - nx) <= 1) || k == 15;
            chk(sx9(estimate) == nx, "R1 R3 estimate", sx9(estimate), nx);
            chk(int'(iter_cnt) == k, "R3 count", int'(iter_cnt), k);
            chk(converged == done_e, "R4 R6 converged", int'(converged), int'(done_e));
            mx = nx;
            if (done_e) break;
        end
        if (exp_x >= 0) chk(int'(estimate) == exp_x, "R4 R9 final", int'(estimate), exp_x);
        if (exp_n >= 0) chk(int'(iter_cnt) == exp_n, "R4 R9 updates", int'(iter_cnt), exp_n);
    endtask

    task automatic t_hold();
        logic [8:0] x0;
        logic [3:0] n0;
        x0 = estimate; n0 = iter_cnt;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk); divisor = 9'(k * 37);
            chk(estimate == x0, "R5 estimate held", int'(estimate), int'(x0));
            chk(iter_cnt == n0, "R5 count held", int'(iter_cnt), int'(n0));
            chk(converged, "R5 flag held", int'(converged), 1);
        end
    endtask

    task automatic t_restart();
        @(negedge clk); divisor = 9'h080; start = 1'b1;
        @(negedge clk); start = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(iter_cnt == 2 && !converged, "R7 mid-run", int'(iter_cnt), 2);
        divisor = 9'h000; start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(estimate == 9'h040, "R7 seed reload", int'(estimate), 64);
        chk(iter_cnt == 0 && !converged, "R7 cleared", int'(iter_cnt), 0);
        for (int k = 0; k < 3; k++) @(negedge clk);
        chk(estimate == 9'h0FF && converged, "R7 new result", int'(estimate), 255);
    endtask

    task automatic t_limit();
        @(negedge clk); divisor = 9'h080; start_l = 1'b1;
        @(negedge clk); start_l = 1'b0;
        @(negedge clk);
        chk(estimate_l == 9'h060 && !converged_l, "R6 first update", int'(estimate_l), 96);
        @(negedge clk);
        chk(estimate_l == 9'h078, "R6 limit value", int'(estimate_l), 120);
        chk(converged_l && iter_cnt_l == 2'd2, "R6 forced stop", int'(converged_l), 1);
        @(negedge clk);
        chk(estimate_l == 9'h078 && converged_l, "R6 held", int'(estimate_l), 120);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_case(9'h080, 9'h07F, 4);
        t_hold();
        t_case(9'h0C0, -1, -1);
        t_case(9'h042, -1, -1);
        t_case(9'h0FF, -1, -1);
        t_case(9'h063, -1, -1);
        t_case(9'h082, -1, -1);
        t_case(9'h040, 9'h0FF, 5);
        t_case(9'h010, -1, -1);
        t_case(9'h180, 9'h0FF, 3);
        t_case(9'h000, 9'h0FF, 3);
        t_case(9'h100, 9'h0FF, 3);
        t_restart();
        t_limit();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule